// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer peripheral with a small word-addressed register interface on the bus clock. A slow timebase arrives as a one-cycle strobe, `slow_tick`, in the bus clock domain, at roughly 32 kHz. An up-counter advances on that timebase through an optional power-of-two prescaler. When it wraps past all ones while running, the block raises a reset request for a fixed number of slow ticks and reloads the counter from the load register.

Software can only start or stop the timer by writing two key words in the right order to the key register. A plain write cannot change the run state. The timeout is set through the load register. Software services the watchdog by writing the trigger register with a value that differs from its current contents, which reloads the counter. Every write to the control, load, trigger or key register is posted. It takes effect only on the second slow tick after the write. Until then, a per-register pending bit stays set and further writes to that register are dropped.

The key-sequence FSM has four named states:

- **STOPPED**: the reset state.
- **START_ARMED**: the first start word has been seen while stopped.
- **RUNNING**: the counter advances.
- **STOP_ARMED**: the first stop word has been seen while running.

Its transitions are these:

- STOPPED to START_ARMED on 0xBBBB.
- START_ARMED to RUNNING on 0x4444.
- START_ARMED back to STOPPED on any other word.
- RUNNING to STOP_ARMED on 0xAAAA.
- STOP_ARMED to STOPPED on 0x5555.
- STOP_ARMED back to RUNNING on any other word.
- Any other word seen in STOPPED or RUNNING leaves the state unchanged.

Top module: `wdg_keyed_timer`

## Requirements
- R1: After reset the timer is stopped, the count, load and control registers read 0, the pending register reads 0, the reset request is low, and slow ticks do not change the count.
- R2: A committed key write of 0x0000BBBB followed by a committed key write of 0x00004444 starts the timer. While running, the count rises by one per prescaler step.
- R3: A committed 0x0000AAAA followed by a committed 0x00005555 stops the timer, and the count then holds.
- R4: If the first word of a start or stop pair is followed by any other key word, the pair is discarded and the run state stays as it was.
- R5: A committed trigger write whose value differs from the stored trigger value reloads the count from the load register. A committed write of the same value leaves the count unchanged.
- R6: Control register bit 5 enables the prescaler and bits 4:2 hold the prescaler value P. With the prescaler enabled, the count steps once every 2^P slow ticks; with it disabled, the count steps on every tick. Control reads back only bits 5:2.
- R7: Pending register bit 0 is set by a control write, bit 2 by a load write, bit 3 by a trigger write and bit 4 by a key write. A pending bit is set from the cycle after the write. It clears on the second slow tick after the write, and the written value takes effect on that same tick.
- R8: A write to a register whose pending bit is set is ignored.
- R9: When the running count steps past 0xFFFFFFFF, the reset request goes high for RST_TICKS (4) slow ticks and the count reloads from the load register.
- R10: The revision register returns REV_CODE (0x31) in bits 7:0 and zero above.
- R11: Word address map:
  - 0: revision
  - 1: control
  - 2: load
  - 3: trigger
  - 4: key
  - 5: pending
  - 6: current count

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle slow timebase strobe, synchronous to clk |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_reset_req | output | 1 | Reset request raised on counter wrap |

## Verification
The hardest condition to reach from the ports is the counter wrap that raises the reset request. From zero it would take 2^32 ticks. The stimulus avoids this by loading 0xFFFFFFF0, writing a new trigger value to force a reload, and then starting the timer, so the wrap arrives after 16 ticks. Overlapping posted writes are the second awkward case. They are produced by issuing bus writes between individual slow ticks, so a second write lands while the first is still pending.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [2:0] {
        A_REV   = 3'd0,
        A_CTRL  = 3'd1,
        A_LOAD  = 3'd2,
        A_TRIG  = 3'd3,
        A_KEY   = 3'd4,
        A_PEND  = 3'd5,
        A_COUNT = 3'd6
    } reg_addr_t;

    typedef enum logic [1:0] {
        KS_STOPPED,
        KS_START_ARMED,
        KS_RUNNING,
        KS_STOP_ARMED
    } key_state_t;

    localparam logic [31:0] KEY_START_A = 32'h0000_BBBB;
    localparam logic [31:0] KEY_START_B = 32'h0000_4444;
    localparam logic [31:0] KEY_STOP_A  = 32'h0000_AAAA;
    localparam logic [31:0] KEY_STOP_B  = 32'h0000_5555;

    localparam int N_SLOTS = 4;
    localparam int SL_CTRL = 0;
    localparam int SL_LOAD = 1;
    localparam int SL_TRIG = 2;
    localparam int SL_KEY  = 3;

    localparam int PRE_W = 3;
    localparam logic [31:0] CTRL_MASK = 32'h0000_003C;

    function automatic logic [2:0] slot_addr(input int idx);
        case (idx)
            SL_CTRL: slot_addr = A_CTRL;
            SL_LOAD: slot_addr = A_LOAD;
            SL_TRIG: slot_addr = A_TRIG;
            default: slot_addr = A_KEY;
        endcase
    endfunction

endpackage

// File: rtl/wdg_post_slot.sv
module wdg_post_slot #(
    parameter int DW         = 32,
    parameter int SYNC_TICKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    output logic          pending,
    output logic          commit,
    output logic [DW-1:0] held
);
    localparam int CW = $clog2(SYNC_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

    logic [CW-1:0] tick_cnt;

    assign commit = pending && tick && (tick_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            tick_cnt <= '0;
            held     <= '0;
        end else if (!pending) begin
            if (wr_req) begin
                pending  <= 1'b1;
                held     <= wr_data;
                tick_cnt <= '0;
            end
        end else if (tick) begin
            if (tick_cnt == LAST) begin
                pending  <= 1'b0;
                tick_cnt <= '0;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm
    import wdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_commit,
    input  logic [31:0] key_word,
    output logic        running
);
    key_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (key_commit) begin
            unique case (state_q)
                KS_STOPPED:
                    if (key_word == KEY_START_A) state_d = KS_START_ARMED;
                KS_START_ARMED:
                    state_d = (key_word == KEY_START_B) ? KS_RUNNING : KS_STOPPED;
                KS_RUNNING:
                    if (key_word == KEY_STOP_A) state_d = KS_STOP_ARMED;
                KS_STOP_ARMED:
                    state_d = (key_word == KEY_STOP_B) ? KS_STOPPED : KS_RUNNING;
                default:
                    state_d = KS_STOPPED;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            KS_RUNNING, KS_STOP_ARMED: running = 1'b1;
            default:                   running = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pre_en,
    input  logic [PW-1:0] pre_val,
    output logic          step
);
    localparam int DIV_W = (1 << PW) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_mask;

    assign div_mask = DIV_W'((1 << pre_val) - 1);
    assign step     = tick && (!pre_en || (div_cnt == div_mask));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!pre_en) begin
            div_cnt <= '0;
        end else if (tick) begin
            if (div_cnt == div_mask) div_cnt <= '0;
            else                     div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
    parameter int CNT_W     = 32,
    parameter int RST_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             step,
    input  logic             running,
    input  logic             reload_req,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             rst_req
);
    localparam int PW = $clog2(RST_TICKS + 1);

    logic [PW-1:0] pulse_cnt;
    logic          wrap;

    assign wrap    = step && running && (count == '1) && !reload_req;
    assign rst_req = (pulse_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (reload_req || wrap) begin
            count <= load_val;
        end else if (step && running) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
        end else if (wrap) begin
            pulse_cnt <= PW'(RST_TICKS);
        end else if (tick && pulse_cnt != '0) begin
            pulse_cnt <= pulse_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wdg_keyed_timer.sv
module wdg_keyed_timer
    import wdg_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter int          RST_TICKS  = 4,
    parameter int          SYNC_TICKS = 2,
    parameter logic [7:0]  REV_CODE   = 8'h31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_tick,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_reset_req
);
    logic [N_SLOTS-1:0] slot_pend;
    logic [N_SLOTS-1:0] slot_commit;
    logic [31:0]        slot_held [N_SLOTS];

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        wdg_post_slot #(.DW(32), .SYNC_TICKS(SYNC_TICKS)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (slow_tick),
            .wr_req  (bus_wr && (bus_addr == slot_addr(i))),
            .wr_data (bus_wdata),
            .pending (slot_pend[i]),
            .commit  (slot_commit[i]),
            .held    (slot_held[i])
        );
    end

    logic [31:0]      ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic [31:0]      trig_q;
    logic             trig_reload;
    logic             key_commit;
    logic             running;
    logic             step;
    logic [CNT_W-1:0] count_q;

    assign trig_reload = slot_commit[SL_TRIG] && (slot_held[SL_TRIG] != trig_q);
    assign key_commit  = slot_commit[SL_KEY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
            trig_q <= '0;
        end else begin
            if (slot_commit[SL_CTRL]) ctrl_q <= slot_held[SL_CTRL];
            if (slot_commit[SL_LOAD]) load_q <= slot_held[SL_LOAD][CNT_W-1:0];
            if (slot_commit[SL_TRIG]) trig_q <= slot_held[SL_TRIG];
        end
    end

    wdg_key_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_commit (key_commit),
        .key_word   (slot_held[SL_KEY]),
        .running    (running)
    );

    wdg_prescaler #(.PW(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (slow_tick),
        .pre_en  (ctrl_q[5]),
        .pre_val (ctrl_q[4:2]),
        .step    (step)
    );

    wdg_counter #(.CNT_W(CNT_W), .RST_TICKS(RST_TICKS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (slow_tick),
        .step       (step),
        .running    (running),
        .reload_req (trig_reload),
        .load_val   (load_q),
        .count      (count_q),
        .rst_req    (wdt_reset_req)
    );

    logic [31:0] pend_word;
    always_comb begin
        pend_word    = '0;
        pend_word[0] = slot_pend[SL_CTRL];
        pend_word[2] = slot_pend[SL_LOAD];
        pend_word[3] = slot_pend[SL_TRIG];
        pend_word[4] = slot_pend[SL_KEY];
    end

    always_comb begin
        unique case (bus_addr)
            A_REV:   bus_rdata = {24'd0, REV_CODE};
            A_CTRL:  bus_rdata = ctrl_q & CTRL_MASK;
            A_LOAD:  bus_rdata = 32'(load_q);
            A_TRIG:  bus_rdata = trig_q;
            A_KEY:   bus_rdata = '0;
            A_PEND:  bus_rdata = pend_word;
            A_COUNT: bus_rdata = 32'(count_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdg_keyed_checker.sv
module wdg_keyed_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slow_tick,
    input logic             running,
    input logic             key_commit,
    input logic             trig_reload,
    input logic [CNT_W-1:0] count,
    input logic             rst_req,
    input logic [3:0]       pend
);
    assert_start_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(key_commit));

    assert_stop_by_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(key_commit));

    assert_stopped_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(running) && !$past(trig_reload)) |-> $stable(count));

    assert_count_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> $past(slow_tick));

    assert_pend_clear_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pend) & ~pend)) |-> $past(slow_tick));

    assert_rst_after_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(count) == '1 && $past(running)));
endmodule

bind wdg_keyed_timer wdg_keyed_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_tick   (slow_tick),
    .running     (running),
    .key_commit  (key_commit),
    .trig_reload (trig_reload),
    .count       (count_q),
    .rst_req     (wdt_reset_req),
    .pend        (slot_pend)
);

// File: tb/sim_wdg_keyed_timer.sv
module sim_wdg_keyed_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_reset_req;

    int errors = 0;
    int checks = 0;

    wdg_keyed_timer u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_reset_req(wdt_reset_req)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        slow_tick = 1'b0;
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) slow_tick = 1'b1;
            @(negedge clk) slow_tick = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic post(input logic [2:0] a, input logic [31:0] d);
        wr(a, d);
        ticks(2);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(3'd6, v); check("R1 count", v, 32'h0);
        rd(3'd2, v); check("R1 load", v, 32'h0);
        rd(3'd1, v); check("R1 ctrl", v, 32'h0);
        rd(3'd5, v); check("R1 pend", v, 32'h0);
        check("R1 rst_req", {31'd0, wdt_reset_req}, 32'h0);
        ticks(3);
        rd(3'd6, v); check("R1 stopped count", v, 32'h0);
        rd(3'd0, v); check("R10 R11 revision", v, 32'h31);
    endtask

    task automatic t_start_stop();
        logic [31:0] v;
        do_reset();
        post(3'd2, 32'h10);
        post(3'd3, 32'h1);
        rd(3'd6, v); check("R5 reload", v, 32'h10);
        post(3'd4, 32'hBBBB);
        post(3'd4, 32'h4444);
        rd(3'd6, v); check("R2 start point", v, 32'h10);
        ticks(3);
        rd(3'd6, v); check("R2 running", v, 32'h13);
        post(3'd4, 32'hAAAA);
        post(3'd4, 32'h5555);
        rd(3'd6, v); check("R3 stop point", v, 32'h17);
        ticks(3);
        rd(3'd6, v); check("R3 held", v, 32'h17);
    endtask

    task automatic t_broken();
        logic [31:0] v;
        do_reset();
        post(3'd2, 32'h20);
        post(3'd3, 32'h5);
        post(3'd4, 32'hBBBB);
        post(3'd4, 32'h1234);
        post(3'd4, 32'h4444);
        ticks(3);
        rd(3'd6, v); check("R4 start discarded", v, 32'h20);
        post(3'd4, 32'hBBBB);
        post(3'd4, 32'h4444);
        ticks(2);
        rd(3'd6, v); check("R2 start after discard", v, 32'h22);
        post(3'd4, 32'hAAAA);
        post(3'd4, 32'h7777);
        ticks(1);
        rd(3'd6, v); check("R4 stop discarded", v, 32'h27);
    endtask

    task automatic t_trigger();
        logic [31:0] v;
        do_reset();
        post(3'd2, 32'h40);
        post(3'd3, 32'h0);
        rd(3'd6, v); check("R5 same value no reload", v, 32'h0);
        post(3'd3, 32'h9);
        rd(3'd6, v); check("R5 new value reload", v, 32'h40);
        post(3'd2, 32'h80);
        post(3'd3, 32'h9);
        rd(3'd6, v); check("R5 repeat no reload", v, 32'h40);
        post(3'd3, 32'hA);
        rd(3'd6, v); check("R5 reload new load", v, 32'h80);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        do_reset();
        post(3'd1, 32'hFFFF_FFEB);
        rd(3'd1, v); check("R6 ctrl readback", v, 32'h28);
        post(3'd4, 32'hBBBB);
        post(3'd4, 32'h4444);
        ticks(7);
        rd(3'd6, v); check("R6 div4 after 7", v, 32'h1);
        ticks(1);
        rd(3'd6, v); check("R6 div4 after 8", v, 32'h2);
    endtask

    task automatic t_pending();
        logic [31:0] v;
        do_reset();
        wr(3'd2, 32'h55);
        rd(3'd5, v); check("R7 load pending", v, 32'h04);
        ticks(1);
        rd(3'd5, v); check("R7 still pending", v, 32'h04);
        rd(3'd2, v); check("R7 not yet applied", v, 32'h0);
        wr(3'd2, 32'h66);
        ticks(1);
        rd(3'd5, v); check("R7 cleared", v, 32'h0);
        rd(3'd2, v); check("R8 second write ignored", v, 32'h55);
        wr(3'd1, 32'h04);
        wr(3'd3, 32'h3);
        wr(3'd4, 32'h1111);
        rd(3'd5, v); check("R7 bits 0 3 4", v, 32'h19);
        ticks(2);
        rd(3'd5, v); check("R7 all cleared", v, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        do_reset();
        post(3'd2, 32'hFFFF_FFF0);
        post(3'd3, 32'h1);
        post(3'd4, 32'hBBBB);
        post(3'd4, 32'h4444);
        ticks(15);
        rd(3'd6, v); check("R9 at all ones", v, 32'hFFFF_FFFF);
        check("R9 no req yet", {31'd0, wdt_reset_req}, 32'h0);
        ticks(1);
        rd(3'd6, v); check("R9 reloaded", v, 32'hFFFF_FFF0);
        check("R9 req high", {31'd0, wdt_reset_req}, 32'h1);
        ticks(3);
        check("R9 req held", {31'd0, wdt_reset_req}, 32'h1);
        ticks(1);
        check("R9 req ended", {31'd0, wdt_reset_req}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_start_stop();
        t_broken();
        t_trigger();
        t_prescale();
        t_pending();
        t_overflow();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule